// File: doc/BRIEF.md
# Serial-Programmed Digital Potentiometer Controller

This block holds the control logic of a 128-step digital potentiometer. A host writes a 7-bit wiper code over a three-wire serial port: a select line, a serial clock and a data line. Data bits enter a shift register most significant bit first, one bit on each rising serial clock edge while the select line is low. When the select line goes high again, the shift register contents are copied into the wiper register. The wiper register decodes to one of 128 tap-switch enables. Code 0 closes the switch at the B end of the ladder, and each higher code closes the next tap up.

An open-drain serial output carries the bits that fall out of the shift register. Several devices can therefore share one select line with their data lines chained: the first word clocked in travels on to the far device. A preset input forces the wiper to midscale. A shutdown input opens the A-terminal switch and shorts the wiper to the B terminal without losing the stored code, and writes made during shutdown still update that code. All pins are sampled by a faster system clock through two-flop synchronizers.

Top module: `dpot_ctrl`

## Requirements
- R1: After a frame of exactly 7 bits, sent most significant bit first and closed by the select line rising, the tap enable whose index equals the received code is the only tap enable high.
- R2: Serial clock edges while the select line is high do not shift data. A frame with no clock edges reloads the previous shift register contents, so the wiper code is unchanged.
- R3: If a frame carries more than 7 bits, only the last 7 bits clocked in are kept.
- R4: The serial output presents the bit falling out of the top of the shift register. With two devices chained, a 14-bit frame leaves the first 7 bits in the far device and the last 7 bits in the near device.
- R5: The serial output is a pull-low enable. It is high only while the select line is low and the outgoing bit is 0, and it is low at all other times.
- R6: While the active-low preset input is low, the wiper code is forced to midscale (64). This takes priority over a frame completing at the same time.
- R7: While the active-low shutdown input is low, all tap enables are low, the A-terminal switch enable is low and the short enable is high. The stored code reappears when shutdown is released.
- R8: A frame that completes during shutdown updates the wiper code, and the new code takes effect when shutdown is released.
- R9: Code 0 enables tap 0, the B-end switch, and code 127 enables tap 127.
- R10: The synchronous active-high system reset sets the wiper code to midscale with shutdown inactive, and releases the serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high system reset |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data captured on its rising edge |
| sdi | input | 1 | Serial data in |
| preset_n | input | 1 | Active-low midscale preset |
| shdn_n | input | 1 | Active-low shutdown |
| sdo_pull_low | output | 1 | Open-drain serial out: 1 pulls the line low |
| tap_en | output | 128 | One-hot tap switch enables; bit 0 is the B end |
| a_sw_en | output | 1 | A-terminal switch enable |
| short_en | output | 1 | Wiper-to-B short enable used in shutdown |

## Verification
The decode is tried with codes that have alternating bit patterns (0x2A, 0x55), which would expose a reversed bit order or a shift off by one position, and with the end codes 0 and 127. Frames of 10 bits and frames with no clock edges show whether the block keeps exactly the last seven bits and ignores edges outside a frame. A 14-bit frame across two chained instances shows that the serial output carries the previous word with the right delay. Preset and shutdown are asserted around frames, including a frame that completes inside each window, to check priority and code retention.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    localparam int CODE_W   = 7;
    localparam int TAPS     = 1 << CODE_W;
    localparam int MID_CODE = TAPS / 2;
    localparam int PIN_W    = 5;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [TAPS-1:0]   taps_t;

    typedef struct packed {
        logic sclk;
        logic sel_n;
        logic sdi;
        logic shdn_n;
        logic preset_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, sel_n: 1'b1, sdi: 1'b0,
                                    shdn_n: 1'b1, preset_n: 1'b1};

    typedef struct packed {
        logic  a_sw_en;
        logic  short_en;
        taps_t tap_en;
    } sw_ctl_t;

    function automatic taps_t tap_decode(input code_t c);
        taps_t t;
        t    = '0;
        t[c] = 1'b1;
        return t;
    endfunction

    function automatic sw_ctl_t switch_state(input code_t c, input logic shdn_n);
        sw_ctl_t s;
        if (shdn_n) begin
            s.a_sw_en  = 1'b1;
            s.short_en = 1'b0;
            s.tap_en   = tap_decode(c);
        end else begin
            s.a_sw_en  = 1'b0;
            s.short_en = 1'b1;
            s.tap_en   = '0;
        end
        return s;
    endfunction

endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/dpot_serial.sv
module dpot_serial
    import dpot_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk_s,
    input  logic  sel_n_s,
    input  logic  sdi_s,
    output logic  load,
    output code_t frame,
    output logic  sdo_pull_low
);
    logic  sclk_d;
    logic  sel_n_d;
    code_t shreg;
    logic  shift_en;

    assign shift_en = sclk_s && !sclk_d && !sel_n_s;
    assign load     = sel_n_s && !sel_n_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            sel_n_d <= 1'b1;
            shreg   <= '0;
        end else begin
            sclk_d  <= sclk_s;
            sel_n_d <= sel_n_s;
            if (shift_en) shreg <= {shreg[CODE_W-2:0], sdi_s};
        end
    end

    assign frame        = shreg;
    assign sdo_pull_low = !sel_n_s && !shreg[CODE_W-1];
endmodule

// File: rtl/dpot_wiper.sv
module dpot_wiper
    import dpot_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  preset_n_s,
    input  logic  load,
    input  code_t frame,
    output code_t code_q
);
    always_ff @(posedge clk) begin
        if (rst)              code_q <= code_t'(MID_CODE);
        else if (!preset_n_s) code_q <= code_t'(MID_CODE);
        else if (load)        code_q <= frame;
    end
endmodule

// File: rtl/dpot_switch.sv
module dpot_switch
    import dpot_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  code_t   code,
    input  logic    shdn_n_s,
    output sw_ctl_t ctl
);
    always_ff @(posedge clk) begin
        if (rst) ctl <= switch_state(code_t'(MID_CODE), 1'b1);
        else     ctl <= switch_state(code, shdn_n_s);
    end
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
    import dpot_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sel_n,
    input  logic            sclk,
    input  logic            sdi,
    input  logic            preset_n,
    input  logic            shdn_n,
    output logic            sdo_pull_low,
    output logic [TAPS-1:0] tap_en,
    output logic            a_sw_en,
    output logic            short_en
);
    pins_t   pins_raw;
    pins_t   pins_s;
    logic    load;
    code_t   frame;
    code_t   code_q;
    sw_ctl_t ctl;

    assign pins_raw = '{sclk: sclk, sel_n: sel_n, sdi: sdi,
                        shdn_n: shdn_n, preset_n: preset_n};

    dpot_sync #(.WIDTH(PIN_W), .STAGES(2), .RST_VAL(PINS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    dpot_serial u_serial (
        .clk          (clk),
        .rst          (rst),
        .sclk_s       (pins_s.sclk),
        .sel_n_s      (pins_s.sel_n),
        .sdi_s        (pins_s.sdi),
        .load         (load),
        .frame        (frame),
        .sdo_pull_low (sdo_pull_low)
    );

    dpot_wiper u_wiper (
        .clk        (clk),
        .rst        (rst),
        .preset_n_s (pins_s.preset_n),
        .load       (load),
        .frame      (frame),
        .code_q     (code_q)
    );

    dpot_switch u_switch (
        .clk      (clk),
        .rst      (rst),
        .code     (code_q),
        .shdn_n_s (pins_s.shdn_n),
        .ctl      (ctl)
    );

    assign tap_en   = ctl.tap_en;
    assign a_sw_en  = ctl.a_sw_en;
    assign short_en = ctl.short_en;
endmodule

// File: rtl/dpot_ctrl_checker.sv
module dpot_ctrl_checker
    import dpot_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            sdo_pull_low,
    input logic [TAPS-1:0] tap_en,
    input logic            a_sw_en,
    input logic            short_en,
    input pins_t           pins_s,
    input logic            load,
    input code_t           frame,
    input code_t           code_q
);
    // R1: outside shutdown exactly one tap switch is closed
    a_r1_one_tap: assert property (@(posedge clk) disable iff (rst)
        !short_en |-> ($countones(tap_en) == 1 && a_sw_en));

    // R7: shutdown state opens every tap and the A switch
    a_r7_shdn_open: assert property (@(posedge clk) disable iff (rst)
        short_en |-> (tap_en == '0 && !a_sw_en));

    // R5: serial output released while the port is deselected
    a_r5_sdo_release: assert property (@(posedge clk) disable iff (rst)
        pins_s.sel_n |-> !sdo_pull_low);

    // R6: preset forces midscale on the next cycle
    a_r6_preset_mid: assert property (@(posedge clk) disable iff (rst)
        !pins_s.preset_n |=> code_q == code_t'(MID_CODE));

    // R8: a completed frame is stored whatever the shutdown input does
    a_r8_load_stores: assert property (@(posedge clk) disable iff (rst)
        (load && pins_s.preset_n) |=> code_q == $past(frame));

    // R10: leaving reset the code is midscale
    a_r10_reset_mid: assert property (@(posedge clk)
        $fell(rst) |-> code_q == code_t'(MID_CODE));
endmodule

bind dpot_ctrl dpot_ctrl_checker u_checker (
    .clk          (clk),
    .rst          (rst),
    .sdo_pull_low (sdo_pull_low),
    .tap_en       (tap_en),
    .a_sw_en      (a_sw_en),
    .short_en     (short_en),
    .pins_s       (pins_s),
    .load         (load),
    .frame        (frame),
    .code_q       (code_q)
);

// File: tb/dpot_ctrl_test.sv
module dpot_ctrl_test;
    import dpot_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic preset_n = 1'b1, shdn_n = 1'b1;
    logic sdo_pull_low, far_pull;
    logic [TAPS-1:0] tap_en, far_taps;
    logic a_sw_en, short_en, far_a, far_short;
    logic chain_line;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    code;
        logic  off;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // open-drain line with an external pull-up
    assign chain_line = sdo_pull_low ? 1'b0 : 1'b1;

    dpot_ctrl uut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
        .preset_n(preset_n), .shdn_n(shdn_n), .sdo_pull_low(sdo_pull_low),
        .tap_en(tap_en), .a_sw_en(a_sw_en), .short_en(short_en)
    );

    dpot_ctrl uut_far (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdi(chain_line),
        .preset_n(1'b1), .shdn_n(1'b1), .sdo_pull_low(far_pull),
        .tap_en(far_taps), .a_sw_en(far_a), .short_en(far_short)
    );

    function automatic logic [TAPS-1:0] one_tap(input int c);
        logic [TAPS-1:0] t = '0;
        t[c] = 1'b1;
        return t;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp_v);
        end
    endtask

    task automatic check_state(input string req, input logic [TAPS-1:0] taps,
                               input logic a, input logic s, input int code, input logic off);
        logic [TAPS-1:0] et;
        logic ea, es;
        et = off ? '0 : one_tap(code);
        ea = !off;
        es = off;
        checks++;
        if (taps !== et || a !== ea || s !== es) begin
            errors++;
            $display("FAIL %s: got taps=%h a=%b short=%b expected taps=%h a=%b short=%b",
                     req, taps, a, s, et, ea, es);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        sel_n = 1'b0;
        wait_clk(HALF_BIT);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i];
            wait_clk(HALF_BIT);
            sclk = 1'b1;
            wait_clk(HALF_BIT);
            sclk = 1'b0;
        end
        wait_clk(HALF_BIT);
        sel_n = 1'b1;
        wait_clk(HALF_BIT);
    endtask

    // driver: push what the outputs should show, then wait for the monitor
    task automatic expect_state(input int code, input logic off, input string tag);
        sb_q.push_back('{code: code, off: off, tag: tag});
        while (sb_q.size() != 0) @(negedge clk);
        wait_clk(2);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                exp_t e;
                wait_clk(3);
                e = sb_q.pop_front();
                check_state(e.tag, tap_en, a_sw_en, short_en, e.code, e.off);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R10: reset state
        check_state("R10 reset", tap_en, a_sw_en, short_en, MID_CODE, 1'b0);
        check_bit("R10 sdo released", sdo_pull_low, 1'b0);

        // R1: alternating patterns
        send_bits(32'h2A, 7);
        expect_state(32'h2A, 1'b0, "R1 code 0x2A");
        // R2: clock edges with select high are ignored; empty frame keeps code
        sdi = 1'b1;
        for (int i = 0; i < 7; i++) begin
            wait_clk(HALF_BIT); sclk = 1'b1; wait_clk(HALF_BIT); sclk = 1'b0;
        end
        send_bits(32'h0, 0);
        expect_state(32'h2A, 1'b0, "R2 idle clocks ignored");
        send_bits(32'h55, 7);
        expect_state(32'h55, 1'b0, "R1 code 0x55");

        // R9: end codes
        send_bits(32'h00, 7);
        expect_state(0, 1'b0, "R9 code 0 B end");
        send_bits(32'h7F, 7);
        expect_state(127, 1'b0, "R9 code 127");

        // R3: ten bits, last seven kept
        send_bits({22'd0, 3'b111, 7'h13}, 10);
        expect_state(32'h13, 1'b0, "R3 overlength frame");

        // R5: released while deselected even though outgoing bit is 0
        check_bit("R5 sdo released when deselected", sdo_pull_low, 1'b0);
        // R4: outgoing bit of stored 0x13 is 0, so the line is pulled low
        sel_n = 1'b0;
        wait_clk(4);
        check_bit("R4 sdo shows previous frame msb", sdo_pull_low, 1'b1);
        sel_n = 1'b1;
        wait_clk(6);
        send_bits(32'h55, 7);
        sel_n = 1'b0;
        wait_clk(4);
        check_bit("R4 sdo released for msb 1", sdo_pull_low, 1'b0);
        sel_n = 1'b1;
        wait_clk(6);

        // R4: daisy chain of two, 14 bits
        send_bits({18'd0, 7'h21, 7'h5E}, 14);
        expect_state(32'h5E, 1'b0, "R4 near device gets last word");
        check_state("R4 far device gets first word", far_taps, far_a, far_short, 32'h21, 1'b0);

        // R6: preset forces midscale, also over a frame completing meanwhile
        preset_n = 1'b0;
        wait_clk(4);
        expect_state(MID_CODE, 1'b0, "R6 preset midscale");
        send_bits(32'h11, 7);
        expect_state(MID_CODE, 1'b0, "R6 preset beats frame");
        preset_n = 1'b1;
        wait_clk(4);
        send_bits(32'h30, 7);
        expect_state(32'h30, 1'b0, "R6 writes resume after preset");

        // R7: shutdown and restore
        shdn_n = 1'b0;
        wait_clk(4);
        expect_state(32'h30, 1'b1, "R7 shutdown state");
        check_bit("R7 short on", short_en, 1'b1);
        shdn_n = 1'b1;
        wait_clk(4);
        expect_state(32'h30, 1'b0, "R7 code restored");

        // R8: write during shutdown
        shdn_n = 1'b0;
        wait_clk(4);
        send_bits(32'h0F, 7);
        expect_state(32'h0F, 1'b1, "R8 still off after write");
        shdn_n = 1'b1;
        wait_clk(4);
        expect_state(32'h0F, 1'b0, "R8 new code after release");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule